// File: doc/BRIEF.md
# Serial Panel Register Writer

This block turns one register write request into a single 32-bit serial frame for a display panel controller on a write-only SPI-style link. The host presents an 8-bit register address and an 8-bit value with a valid/ready handshake. The block latches both, builds the frame and shifts it out most-significant bit first on a serial clock, a data line and an active-high chip select. When the last bit period has ended, it raises a one-cycle completion pulse.

The serial clock is the system clock divided by a parameter, 16 by default. The clock idles high. Each bit period starts with a falling edge that moves the data line, and ends its first half with a rising edge at which the panel samples. An enable input gates the whole link. While enable is low, the outputs hold their idle levels and no request is taken. Dropping enable in the middle of a frame aborts it.

Top module: `panel_reg_writer`

## Requirements
- R1: The frame is 32 bits. Bits 31..24 are 0x00, bits 23..16 are the register address, bits 15..8 are the marker 0x01 and bits 7..0 are the data value. It is sent bit 31 first, and the address and data are latched at acceptance.
- R2: All 32 bits are sent within one continuous chip-select assertion with no gap. Chip select is active high and stays high for exactly 32*DIV system cycles.
- R3: The serial clock idles high. The data line changes only on the falling (leading) edge and is stable while the clock is high, so it is stable across the rising (sampling) edge.
- R4: Each bit period lasts DIV system cycles: DIV/2 cycles low followed by DIV/2 cycles high.
- R5: A request is accepted on a clock edge where req_valid and req_ready are both high. req_ready equals enable while no frame is in progress. Chip select is high in the cycle after acceptance.
- R6: done is a single-cycle pulse, high 32*DIV cycles after the acceptance edge. In that same cycle chip select falls.
- R7: While a frame is in progress, req_ready is low and a pending request is neither accepted nor allowed to alter the frame. It is accepted once the frame ends.
- R8: While enable is low, req_ready is low, chip select is low and the serial clock is high, whatever req_valid does.
- R9: If enable falls during a frame, the cycle after has chip select low and the serial clock high, and no done pulse is produced for the aborted frame.
- R10: After reset the serial clock is high, chip select, data and done are low, and req_ready follows enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Link enable; low forces idle and aborts a frame |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 8 | Panel register address |
| req_data | input | 8 | Value to write |
| done | output | 1 | One-cycle pulse when a frame has completed |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data out |
| cs | output | 1 | Chip select, active high |

## Verification
A wrong divider count shows up on the first bit as a low or high phase whose length is not DIV/2. A wrong bit counter shows up as a frame whose chip-select window or rising-edge count is not 32*DIV cycles and 32 edges, and the done pulse then arrives at the wrong cycle. A mis-loaded shift register shows up as a wrong captured frame as soon as the frame ends. A busy flag that does not clear after an abort or a frame shows up one cycle later as chip select stuck high, ready stuck low, or a done pulse that should not appear.

// File: rtl/panel_reg_writer.sv
module panel_reg_writer #(
  parameter int          DIV    = 16,
  parameter logic [7:0]  MARKER = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [7:0] req_addr,
  input  logic [7:0] req_data,
  output logic       done,
  output logic       sclk,
  output logic       mosi,
  output logic       cs
);
  localparam int FRAME_W = 32;
  localparam int HALF    = DIV / 2;
  localparam int CW      = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BW      = $clog2(FRAME_W);

  logic               busy;
  logic [CW-1:0]      tick;
  logic [BW-1:0]      nbit;
  logic [FRAME_W-1:0] shreg;

  wire accept    = req_valid && req_ready;
  wire last_tick = (tick == CW'(DIV - 1));
  wire mid_tick  = (tick == CW'(HALF - 1));
  wire last_bit  = (nbit == BW'(FRAME_W - 1));
  wire [FRAME_W-1:0] frame = {8'h00, req_addr, MARKER, req_data};

  assign req_ready = enable && !busy;
  assign cs        = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      tick  <= '0;
      nbit  <= '0;
      shreg <= '0;
      sclk  <= 1'b1;
      mosi  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!enable) begin
        busy <= 1'b0;
        tick <= '0;
        sclk <= 1'b1;
        mosi <= 1'b0;
      end else if (accept) begin
        busy  <= 1'b1;
        tick  <= '0;
        nbit  <= '0;
        sclk  <= 1'b0;
        mosi  <= frame[FRAME_W-1];
        shreg <= {frame[FRAME_W-2:0], 1'b0};
      end else if (busy) begin
        tick <= last_tick ? '0 : tick + CW'(1);
        if (mid_tick) sclk <= 1'b1;
        if (last_tick) begin
          if (last_bit) begin
            busy <= 1'b0;
            done <= 1'b1;
            mosi <= 1'b0;
          end else begin
            nbit  <= nbit + BW'(1);
            sclk  <= 1'b0;
            mosi  <= shreg[FRAME_W-1];
            shreg <= {shreg[FRAME_W-2:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/panel_reg_writer_checks.sv
module panel_reg_writer_checks (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic req_valid,
  input logic req_ready,
  input logic done,
  input logic sclk,
  input logic mosi,
  input logic cs
);
  a_r3_idle_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> sclk);

  a_r3_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && sclk && $past(cs) && $past(sclk)) |-> $stable(mosi));

  a_r5_accept_starts_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> cs);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(cs) && !cs));

  a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cs |-> !req_ready);

  a_r8_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !req_ready);

  a_r9_abort_idles: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs) && !$past(enable)) |-> (!cs && sclk && !done));
endmodule

bind panel_reg_writer panel_reg_writer_checks u_checks (
  .clk(clk), .rst_n(rst_n), .enable(enable), .req_valid(req_valid),
  .req_ready(req_ready), .done(done), .sclk(sclk), .mosi(mosi), .cs(cs)
);

// File: tb/panel_reg_writer_bench.sv
`timescale 1ns/1ps
module panel_reg_writer_bench;
  localparam int DIV  = 16;
  localparam int HALF = DIV / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic req_valid = 1'b0;
  logic [7:0] req_addr = 8'h00;
  logic [7:0] req_data = 8'h00;
  logic req_ready, done, sclk, mosi, cs;

  always #5 clk = ~clk;

  panel_reg_writer #(.DIV(DIV)) u_panel_reg_writer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_data(req_data),
    .done(done), .sclk(sclk), .mosi(mosi), .cs(cs)
  );

  int n_checks = 0;
  int n_fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_frame(input logic [7:0] a, input logic [7:0] d);
    return {8'h00, a, 8'h01, d};
  endfunction

  // link monitor, sampled on falling system clock edges
  logic [31:0] cap, snap_cap;
  int cs_cyc, n_rise, low_run, n_done;
  int snap_cyc, snap_rise;
  bit bad_low, bad_hold, snap_bad_low, snap_bad_hold;
  logic prev_sclk, prev_cs, prev_mosi;

  always @(negedge clk) begin
    if (!rst_n) begin
      cap <= '0; cs_cyc <= 0; n_rise <= 0; low_run <= 0; n_done <= 0;
      bad_low <= 0; bad_hold <= 0;
      prev_sclk <= 1'b1; prev_cs <= 1'b0; prev_mosi <= 1'b0;
    end else begin
      if (done) begin
        n_done <= n_done + 1;
        snap_cap <= cap; snap_cyc <= cs_cyc; snap_rise <= n_rise;
        snap_bad_low <= bad_low; snap_bad_hold <= bad_hold;
      end
      if (cs) begin
        cs_cyc <= cs_cyc + 1;
        if (!sclk) low_run <= low_run + 1;
        if (sclk && !prev_sclk) begin
          cap <= {cap[30:0], mosi};
          n_rise <= n_rise + 1;
          if (low_run != HALF) bad_low <= 1;
          low_run <= 0;
        end
        if (sclk && prev_sclk && prev_cs && mosi != prev_mosi) bad_hold <= 1;
      end else begin
        cap <= '0; cs_cyc <= 0; n_rise <= 0; low_run <= 0;
        bad_low <= 0; bad_hold <= 0;
      end
      prev_sclk <= sclk; prev_cs <= cs; prev_mosi <= mosi;
    end
  end

  // drive a request and return at the first falling edge after acceptance
  task automatic issue(input logic [7:0] a, input logic [7:0] d);
    int w;
    @(negedge clk);
    req_addr = a; req_data = d; req_valid = 1'b1;
    w = 0;
    while (!req_ready && w < 5000) begin @(negedge clk); w++; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr = ~a; req_data = ~d;
    chk(cs == 1'b1, "R5", "cs after accept", cs, 1);
  endtask

  // wait for completion; optionally queue a second request mid-frame
  task automatic finish(input logic [7:0] a, input logic [7:0] d, input bit hold,
                        input logic [7:0] a2, input logic [7:0] d2);
    int lat;
    lat = 1;
    while (!done && lat < 32*DIV + 50) begin
      @(negedge clk);
      lat++;
      if (hold && lat == 50) begin
        req_valid = 1'b1; req_addr = a2; req_data = d2;
      end
      if (hold && lat == 51)
        chk(req_ready == 1'b0, "R7", "ready during frame", req_ready, 0);
    end
    chk(lat == 32*DIV + 1, "R6", "done latency", lat, 32*DIV + 1);
    chk(cs == 1'b0, "R6", "cs falls with done", cs, 0);
    chk(req_ready == 1'b1, "R5", "ready after frame", req_ready, 1);
    @(negedge clk);
    chk(done == 1'b0, "R6", "done one cycle", done, 0);
    chk(snap_cap == exp_frame(a, d), "R1", "frame", snap_cap, exp_frame(a, d));
    chk(snap_rise == 32, "R2", "rising edges", snap_rise, 32);
    chk(snap_cyc == 32*DIV, "R2", "cs cycles", snap_cyc, 32*DIV);
    chk(!snap_bad_low, "R4", "low phase length", snap_bad_low, 0);
    chk(!snap_bad_hold, "R3", "data moved while clock high", snap_bad_hold, 0);
  endtask

  task automatic run_frame(input logic [7:0] a, input logic [7:0] d);
    issue(a, d);
    finish(a, d, 1'b0, 8'h00, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end

  initial begin
    int dn;
    bit bad;
    void'($urandom(32'd1234));
    enable = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(sclk == 1'b1, "R10", "sclk idle", sclk, 1);
    chk(cs == 1'b0, "R10", "cs idle", cs, 0);
    chk(mosi == 1'b0, "R10", "mosi idle", mosi, 0);
    chk(done == 1'b0, "R10", "done idle", done, 0);
    chk(req_ready == 1'b1, "R10", "ready follows enable", req_ready, 1);

    // directed corners of the frame (R1)
    run_frame(8'hFF, 8'h00);
    run_frame(8'h00, 8'hFF);
    run_frame(8'hA5, 8'h5A);
    run_frame(8'h01, 8'h80);

    // R7: request queued during a frame, taken afterwards
    issue(8'h0B, 8'h2F);
    finish(8'h0B, 8'h2F, 1'b1, 8'h27, 8'h10);
    req_valid = 1'b0;
    chk(cs == 1'b1, "R7", "queued request started", cs, 1);
    finish(8'h27, 8'h10, 1'b0, 8'h00, 8'h00);

    // R8: disabled link ignores requests
    @(negedge clk);
    enable = 1'b0; req_valid = 1'b1; req_addr = 8'h06; req_data = 8'h04;
    bad = 0;
    dn = n_done;
    repeat (60) begin
      @(negedge clk);
      if (cs || req_ready || !sclk) bad = 1;
    end
    chk(!bad, "R8", "idle while disabled", bad, 0);
    req_valid = 1'b0;
    @(negedge clk);
    chk(n_done == dn, "R8", "no done while disabled", n_done, dn);
    enable = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R8", "ready after enable", req_ready, 1);

    // R9: abort mid-frame
    issue(8'h33, 8'hCC);
    repeat (100) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(cs == 1'b0, "R9", "cs after abort", cs, 0);
    chk(sclk == 1'b1, "R9", "sclk after abort", sclk, 1);
    chk(req_ready == 1'b0, "R9", "ready while disabled", req_ready, 0);
    dn = n_done;
    repeat (600) @(negedge clk);
    chk(n_done == dn, "R9", "no done for aborted frame", n_done, dn);
    enable = 1'b1;
    run_frame(8'h44, 8'h99);

    // random frames
    for (int i = 0; i < 16; i++) begin
      logic [7:0] ra, rd;
      ra = 8'($urandom);
      rd = 8'($urandom);
      run_frame(ra, rd);
      repeat ($urandom % 4) @(negedge clk);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end
endmodule